// File: doc/BRIEF.md
# Dual-Channel IDE Programmed-I/O Address Router

This block sits behind the host I/O port of a two-channel IDE controller and steers each programmed-I/O access. The address is compared against five programmable base/size windows. These are the command block and control block of the primary channel, the same two blocks of the secondary channel, and the bus-master register window. The decode yields a region type, a channel flag and an offset relative to the matching window. Accesses to a command or control block go to a drive port with a drive index of 0 to 3. Accesses to the bus-master window go to a separate register port.

The router keeps one drive-select bit per channel. It updates that bit by snooping command-block writes to the drive/head register, and it still passes those writes on to the drive. I/O enable gates all traffic. Bus-master enable gates only writes to the bus-master window. An access that matches no window, or that has an unsupported width, is flagged as illegal.

Decode and forwarding are combinational within the request cycle. The drive-select bits are the only state.

Top module: `ide_pio_router`

## Requirements
- R1: Windows are checked in this order: primary command, primary control, secondary command, secondary control, bus-master. The first window with base <= addr < base+size wins. offset_o is addr minus that window's base, and region_o is 1 for command, 2 for control and 3 for bus-master.
- R2: A valid access with I/O enabled that hits no window drives region_o to 0 and raises illegal_o. Nothing is forwarded.
- R3: A window whose base is zero never matches.
- R4: In the bus-master window, an offset below 8 gives chan_o=0 and any offset of 8 or more gives chan_o=1.
- R5: A legal command-block write at offset 6 loads that channel's drive bit from bit 4 of the written data, and the write is still forwarded. Writes at any other offset leave the drive bits unchanged.
- R6: drv_idx_o = 2*chan + drive bit. On the drive-select write itself, the newly written bit is used.
- R7: With io_en_i low, nothing is forwarded, illegal_o stays low, rdata_o is 0 and the drive bits do not change.
- R8: The req_size_i encoding is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for invalid. Size 3 is illegal everywhere. Size 2 is illegal in the command and control blocks and legal in the bus-master window. Illegal accesses are not forwarded.
- R9: A bus-master write is dropped when bm_en_i is low. Bus-master reads are still forwarded.
- R10: A drive access whose index has drv_present_i clear is dropped, and its read returns 0.
- R11: After reset both drive bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_en_i | input | 1 | I/O space enable |
| bm_en_i | input | 1 | Bus-master enable |
| win_base_i | input | 5*ADDR_W | Window bases, in decode-priority order |
| win_size_i | input | 5*ADDR_W | Window sizes in bytes |
| drv_present_i | input | 4 | One bit per attached drive |
| req_valid_i | input | 1 | Access valid |
| req_write_i | input | 1 | 1 for a write |
| req_addr_i | input | ADDR_W | Access address |
| req_size_i | input | 2 | Width code (R8) |
| req_wdata_i | input | DATA_W | Write data |
| region_o | output | 2 | 0 none, 1 command, 2 control, 3 bus-master |
| chan_o | output | 1 | 0 primary, 1 secondary |
| offset_o | output | OFF_W | Window-relative offset |
| illegal_o | output | 1 | Illegal access flag |
| drv_valid_o | output | 1 | Drive port strobe |
| drv_write_o | output | 1 | Drive port write |
| drv_cmd_o | output | 1 | 1 for command block, 0 for control block |
| drv_byte_o | output | 1 | 1-byte access |
| drv_idx_o | output | 2 | Drive index |
| drv_offset_o | output | OFF_W | Drive register offset |
| drv_wdata_o | output | DATA_W | Drive write data |
| drv_rdata_i | input | DATA_W | Drive read data |
| bm_valid_o | output | 1 | Bus-master port strobe |
| bm_write_o | output | 1 | Bus-master port write |
| bm_size_o | output | 2 | Width code |
| bm_offset_o | output | OFF_W | Bus-master register offset |
| bm_wdata_o | output | DATA_W | Bus-master write data |
| bm_rdata_i | input | DATA_W | Bus-master read data |
| rdata_o | output | DATA_W | Read data returned |
| drv_sel_o | output | 2 | Drive bit per channel |

## Verification
The assertions check the following on every cycle:
- nothing moves and nothing is flagged while I/O is disabled;
- a miss is always flagged;
- 4-byte and invalid widths never reach the drive port;
- bus-master writes only pass with bus mastering on;
- no strobe goes to an absent drive;
- the drive bits change only on a qualifying select write.

Some behaviours only the bench scenarios can show. These are the window priority when windows overlap, the unprogrammed zero base, the bus-master channel boundary at offset 8, and the drive index seen on the select write itself and on later accesses.

// File: rtl/ide_rt_pkg.sv
package ide_rt_pkg;
  localparam int NWIN = 5;
  localparam int NCH  = 2;

  typedef enum logic [1:0] {REG_NONE = 2'd0, REG_CMD = 2'd1, REG_CTRL = 2'd2, REG_BM = 2'd3} region_e;
  typedef enum logic [1:0] {SZ_1B = 2'd0, SZ_2B = 2'd1, SZ_4B = 2'd2, SZ_BAD = 2'd3} size_e;

  // window slots, order is decode priority
  localparam int W_PCMD  = 0;
  localparam int W_PCTRL = 1;
  localparam int W_SCMD  = 2;
  localparam int W_SCTRL = 3;
  localparam int W_BM    = 4;
endpackage

// File: rtl/ide_win_match.sv
module ide_win_match #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] off_o
);
  always_comb begin
    off_o = addr_i - base_i;
    hit_o = (base_i != '0) && (addr_i >= base_i) && (off_o < size_i);
  end
endmodule

// File: rtl/ide_win_prio.sv
module ide_win_prio #(
  parameter int N  = 5,
  parameter int AW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         hit_i,
  input  logic [N-1:0][AW-1:0] off_i,
  output logic                 any_o,
  output logic [IW-1:0]        idx_o,
  output logic [AW-1:0]        off_o
);
  always_comb begin
    any_o = |hit_i;
    idx_o = '0;
    off_o = '0;
    // scan downward so the lowest index wins
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        idx_o = IW'(i);
        off_o = off_i[i];
      end
    end
  end
endmodule

// File: rtl/ide_drv_sel.sv
module ide_drv_sel #(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cap_i,
  input  logic [CW-1:0]  cap_chan_i,
  input  logic           cap_bit_i,
  output logic [NCH-1:0] sel_o
);
  logic [NCH-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (cap_i) sel_q[cap_chan_i] <= cap_bit_i;
  end

  assign sel_o = sel_q;

  p_sel_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> sel_q[$past(cap_chan_i)] == $past(cap_bit_i));
  p_sel_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(sel_q));
endmodule

// File: rtl/ide_pio_router.sv
module ide_pio_router
  import ide_rt_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int OFF_W       = 8,
  parameter int BM_CHAN_OFF = 8,
  parameter int SEL_OFF     = 6,
  parameter int DEV_BIT     = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         io_en_i,
  input  logic                         bm_en_i,
  input  logic [NWIN-1:0][ADDR_W-1:0]  win_base_i,
  input  logic [NWIN-1:0][ADDR_W-1:0]  win_size_i,
  input  logic [3:0]                   drv_present_i,
  input  logic                         req_valid_i,
  input  logic                         req_write_i,
  input  logic [ADDR_W-1:0]            req_addr_i,
  input  logic [1:0]                   req_size_i,
  input  logic [DATA_W-1:0]            req_wdata_i,
  output logic [1:0]                   region_o,
  output logic                         chan_o,
  output logic [OFF_W-1:0]             offset_o,
  output logic                         illegal_o,
  output logic                         drv_valid_o,
  output logic                         drv_write_o,
  output logic                         drv_cmd_o,
  output logic                         drv_byte_o,
  output logic [1:0]                   drv_idx_o,
  output logic [OFF_W-1:0]             drv_offset_o,
  output logic [DATA_W-1:0]            drv_wdata_o,
  input  logic [DATA_W-1:0]            drv_rdata_i,
  output logic                         bm_valid_o,
  output logic                         bm_write_o,
  output logic [1:0]                   bm_size_o,
  output logic [OFF_W-1:0]             bm_offset_o,
  output logic [DATA_W-1:0]            bm_wdata_o,
  input  logic [DATA_W-1:0]            bm_rdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic [NCH-1:0]               drv_sel_o
);
  localparam int IW = $clog2(NWIN);

  logic [NWIN-1:0]             hit;
  logic [NWIN-1:0][ADDR_W-1:0] woff;
  logic                        any_hit;
  logic [IW-1:0]               win_idx;
  logic [ADDR_W-1:0]           win_off;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    ide_win_match #(.ADDR_W(ADDR_W)) u_match (
      .base_i(win_base_i[g]),
      .size_i(win_size_i[g]),
      .addr_i(req_addr_i),
      .hit_o (hit[g]),
      .off_o (woff[g])
    );
  end

  ide_win_prio #(.N(NWIN), .AW(ADDR_W)) u_prio (
    .hit_i(hit),
    .off_i(woff),
    .any_o(any_hit),
    .idx_o(win_idx),
    .off_o(win_off)
  );

  region_e region;
  logic    chan;

  always_comb begin
    region = REG_NONE;
    chan   = 1'b0;
    if (any_hit) begin
      unique case (int'(win_idx))
        W_PCMD:  begin region = REG_CMD;  chan = 1'b0; end
        W_PCTRL: begin region = REG_CTRL; chan = 1'b0; end
        W_SCMD:  begin region = REG_CMD;  chan = 1'b1; end
        W_SCTRL: begin region = REG_CTRL; chan = 1'b1; end
        default: begin region = REG_BM;   chan = (win_off >= ADDR_W'(BM_CHAN_OFF)); end
      endcase
    end
  end

  logic act, is_cmd, is_ctrl, is_bm, sz_drv_ok, sz_bm_ok;
  logic cap, eff_bit;
  logic [NCH-1:0] sel_q;

  always_comb begin
    act       = req_valid_i && io_en_i;
    is_cmd    = (region == REG_CMD);
    is_ctrl   = (region == REG_CTRL);
    is_bm     = (region == REG_BM);
    sz_drv_ok = (req_size_i == SZ_1B) || (req_size_i == SZ_2B);
    sz_bm_ok  = (req_size_i != SZ_BAD);
    cap       = act && req_write_i && is_cmd && sz_drv_ok && (win_off == ADDR_W'(SEL_OFF));
    // the select write itself already sees its new drive bit
    eff_bit   = cap ? req_wdata_i[DEV_BIT] : sel_q[chan];
  end

  ide_drv_sel #(.NCH(NCH)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .cap_chan_i(chan),
    .cap_bit_i (req_wdata_i[DEV_BIT]),
    .sel_o     (sel_q)
  );

  always_comb begin
    region_o     = region;
    chan_o       = chan;
    offset_o     = win_off[OFF_W-1:0];
    illegal_o    = act && (!any_hit || (req_size_i == SZ_BAD) ||
                           ((req_size_i == SZ_4B) && (is_cmd || is_ctrl)));
    drv_idx_o    = {chan, eff_bit};
    drv_valid_o  = act && (is_cmd || is_ctrl) && sz_drv_ok && drv_present_i[drv_idx_o];
    drv_write_o  = req_write_i;
    drv_cmd_o    = is_cmd;
    drv_byte_o   = (req_size_i == SZ_1B);
    drv_offset_o = win_off[OFF_W-1:0];
    drv_wdata_o  = req_wdata_i;
    bm_valid_o   = act && is_bm && sz_bm_ok && (!req_write_i || bm_en_i);
    bm_write_o   = req_write_i;
    bm_size_o    = req_size_i;
    bm_offset_o  = win_off[OFF_W-1:0];
    bm_wdata_o   = req_wdata_i;
    rdata_o      = '0;
    if (!req_write_i && drv_valid_o)     rdata_o = drv_rdata_i;
    else if (!req_write_i && bm_valid_o) rdata_o = bm_rdata_i;
    drv_sel_o    = sel_q;
  end

  p_io_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_en_i |-> (!drv_valid_o && !bm_valid_o && !illegal_o && rdata_o == '0));
  p_miss_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && io_en_i && region_o == REG_NONE) |-> (illegal_o && !drv_valid_o && !bm_valid_o));
  p_drv_width_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_valid_o |-> (req_size_i == SZ_1B || req_size_i == SZ_2B));
  p_bm_wr_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bm_valid_o && bm_write_o) |-> bm_en_i);
  p_absent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_valid_o |-> drv_present_i[drv_idx_o]);
  p_fwd_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({drv_valid_o, bm_valid_o}));
endmodule

// File: tb/ide_pio_router_test.sv
module ide_pio_router_test;
  localparam int AW = 32, DW = 32, OW = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic io_en, bm_en;
  logic [4:0][AW-1:0] wbase, wsize;
  logic [3:0] present;
  logic vld, wr;
  logic [AW-1:0] addr;
  logic [1:0] size;
  logic [DW-1:0] wdata;

  logic [1:0] region_o, drv_idx_o, bm_size_o, drv_sel_o;
  logic chan_o, illegal_o, drv_valid_o, drv_write_o, drv_cmd_o, drv_byte_o, bm_valid_o, bm_write_o;
  logic [OW-1:0] offset_o, drv_offset_o, bm_offset_o;
  logic [DW-1:0] drv_wdata_o, bm_wdata_o, rdata_o, drv_rdata, bm_rdata;

  assign drv_rdata = 32'hD000_0000 | {30'b0, drv_idx_o};
  assign bm_rdata  = 32'hB000_0000 | {24'b0, bm_offset_o};

  ide_pio_router uut (
    .clk_i(clk), .rst_ni(rst_ni), .io_en_i(io_en), .bm_en_i(bm_en),
    .win_base_i(wbase), .win_size_i(wsize), .drv_present_i(present),
    .req_valid_i(vld), .req_write_i(wr), .req_addr_i(addr), .req_size_i(size), .req_wdata_i(wdata),
    .region_o(region_o), .chan_o(chan_o), .offset_o(offset_o), .illegal_o(illegal_o),
    .drv_valid_o(drv_valid_o), .drv_write_o(drv_write_o), .drv_cmd_o(drv_cmd_o), .drv_byte_o(drv_byte_o),
    .drv_idx_o(drv_idx_o), .drv_offset_o(drv_offset_o), .drv_wdata_o(drv_wdata_o), .drv_rdata_i(drv_rdata),
    .bm_valid_o(bm_valid_o), .bm_write_o(bm_write_o), .bm_size_o(bm_size_o), .bm_offset_o(bm_offset_o),
    .bm_wdata_o(bm_wdata_o), .bm_rdata_i(bm_rdata), .rdata_o(rdata_o), .drv_sel_o(drv_sel_o)
  );

  int checks = 0, errors = 0;
  string cur_req = "R11";

  // behavioural reference model
  int m_sel[2];
  int e_region, e_chan, e_off, e_idx;
  bit e_illegal, e_dvalid, e_bvalid, e_cap;
  longint e_rdata;

  always @* begin
    int win;
    longint a, b, s;
    bit act;
    win = -1;
    a = longint'(addr);
    for (int i = 4; i >= 0; i--) begin
      b = longint'(wbase[i]);
      s = longint'(wsize[i]);
      if (b != 0 && a >= b && a < b + s) win = i;
    end
    e_off = 0; e_region = 0; e_chan = 0;
    if (win >= 0) begin
      e_off = int'(a - longint'(wbase[win]));
      if (win == 4) begin
        e_region = 3;
        e_chan = (e_off < 8) ? 0 : 1;
      end else begin
        e_region = (win % 2 == 0) ? 1 : 2;
        e_chan = win / 2;
      end
    end
    act = vld && io_en;
    e_illegal = act && (win < 0 || size == 3 || (size == 2 && (e_region == 1 || e_region == 2)));
    e_cap = act && wr && e_region == 1 && size < 2 && e_off == 6;
    e_idx = 2 * e_chan + (e_cap ? int'(wdata[4]) : m_sel[e_chan]);
    e_dvalid = act && (e_region == 1 || e_region == 2) && size < 2 && present[e_idx];
    e_bvalid = act && e_region == 3 && size != 3 && (!wr || bm_en);
    e_rdata = 0;
    if (!wr && e_dvalid) e_rdata = 64'hD000_0000 + e_idx;
    else if (!wr && e_bvalid) e_rdata = 64'hB000_0000 + e_off;
  end

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sel[0] <= 0;
      m_sel[1] <= 0;
    end else if (e_cap) begin
      m_sel[e_chan] <= int'(wdata[4]);
    end
  end

  task automatic chk(string what, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", cur_req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      chk("region", region_o, e_region);
      chk("illegal", illegal_o, e_illegal);
      chk("drv_valid", drv_valid_o, e_dvalid);
      chk("bm_valid", bm_valid_o, e_bvalid);
      chk("rdata", rdata_o, e_rdata);
      chk("drv_sel", drv_sel_o, {m_sel[1][0], m_sel[0][0]});
      if (e_region != 0) begin
        chk("chan", chan_o, e_chan);
        chk("offset", offset_o, e_off);
      end
      if (e_dvalid) chk("drv_idx", drv_idx_o, e_idx);
    end
  end

  task automatic acc(string tag, bit w, logic [AW-1:0] a, logic [1:0] sz, logic [DW-1:0] d);
    cur_req = tag;
    vld = 1'b1; wr = w; addr = a; size = sz; wdata = d;
    @(posedge clk); #1;
    vld = 1'b0;
  endtask

  initial begin
    #(5 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    io_en = 1; bm_en = 1; present = 4'b0111;
    wbase[0] = 32'h1F0; wsize[0] = 8;
    wbase[1] = 32'h3F4; wsize[1] = 4;
    wbase[2] = 32'h170; wsize[2] = 8;
    wbase[3] = 32'h374; wsize[3] = 4;
    wbase[4] = 32'hC000; wsize[4] = 16;
    vld = 0; wr = 0; addr = 0; size = 0; wdata = 0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk("reset drive bits R11", drv_sel_o, 0);
    @(posedge clk); #1;

    // R1 each window and priority
    acc("R1", 0, 32'h1F3, 0, 0);
    acc("R1", 0, 32'h3F6, 1, 0);
    acc("R1", 0, 32'h175, 0, 0);
    acc("R1", 0, 32'h376, 0, 0);
    acc("R1", 0, 32'hC004, 2, 0);
    wbase[2] = 32'h1F0;
    acc("R1", 0, 32'h1F2, 0, 0);
    wbase[4] = 32'h3F4;
    acc("R1", 0, 32'h3F5, 0, 0);
    wbase[2] = 32'h170; wbase[4] = 32'hC000;
    // R2 miss
    acc("R2", 0, 32'h500, 0, 0);
    acc("R2", 1, 32'hC010, 0, 32'hFF);
    // R3 zero base
    wbase[1] = 0;
    acc("R3", 0, 32'h2, 0, 0);
    acc("R3", 1, 32'h0, 0, 0);
    wbase[1] = 32'h3F4;
    // R4 bus-master channel split
    acc("R4", 0, 32'hC007, 0, 0);
    acc("R4", 0, 32'hC008, 0, 0);
    acc("R4", 0, 32'hC00F, 0, 0);
    // R5 / R6 drive select
    acc("R5", 1, 32'h1F6, 0, 32'h10);
    acc("R6", 0, 32'h1F0, 1, 0);
    acc("R5", 1, 32'h1F5, 0, 32'h00);
    acc("R6", 0, 32'h3F6, 0, 0);
    acc("R5", 1, 32'h176, 0, 32'hA0);
    acc("R6", 0, 32'h172, 0, 0);
    acc("R5", 1, 32'h176, 0, 32'hF0);
    // R10 drive 3 absent
    acc("R10", 0, 32'h172, 0, 0);
    acc("R10", 1, 32'h377, 0, 32'h55);
    acc("R5", 1, 32'h1F6, 2, 32'h00);
    acc("R6", 1, 32'h1F6, 1, 32'h00);
    // R7 io disabled
    io_en = 0;
    acc("R7", 1, 32'h1F6, 0, 32'h10);
    acc("R7", 0, 32'h1F0, 0, 0);
    acc("R7", 0, 32'h900, 0, 0);
    acc("R7", 0, 32'hC002, 0, 0);
    io_en = 1;
    acc("R7", 0, 32'h1F0, 0, 0);
    // R8 widths
    acc("R8", 0, 32'h1F0, 2, 0);
    acc("R8", 0, 32'h3F4, 2, 0);
    acc("R8", 1, 32'hC004, 2, 32'h1234);
    acc("R8", 0, 32'hC000, 3, 0);
    acc("R8", 0, 32'h1F1, 3, 0);
    // R9 bus-master enable
    bm_en = 0;
    acc("R9", 1, 32'hC002, 0, 32'h06);
    acc("R9", 0, 32'hC00A, 0, 0);
    bm_en = 1;
    acc("R9", 1, 32'hC002, 0, 32'h06);
    // R11 reset clears drive bits again
    acc("R5", 1, 32'h1F6, 0, 32'h10);
    rst_ni = 0;
    #1;
    cur_req = "R11";
    chk("drive bits in reset R11", drv_sel_o, 0);
    @(posedge clk); #1 rst_ni = 1;
    acc("R11", 0, 32'h1F0, 0, 0);
    repeat (2) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule